// File: doc/BRIEF.md
# ROM Program Patch Substitution Unit

This unit sits on the instruction-fetch path between a CPU and a mask-programmed program memory. It lets firmware swap a faulty instruction word for a new one after the ROM has been made. Each of several independent patch channels holds a 24-bit target byte address, a two-byte replacement word and an enable flag. When an enabled channel's target falls inside the 16-bit word being fetched, the unit holds back the ROM read strobe and puts the replacement word on the internal data bus. Every other fetch passes the ROM data and the read strobe through unchanged.

The usual replacement is a one-byte software-interrupt opcode (F9h) that sends execution to patch code held in RAM. Both halves of the matched word are returned. For an even target, software puts the opcode in the low byte. For an odd target, it puts the opcode in the high byte and copies the original ROM byte from the even address just below into the low byte. Channels are set up through a small synchronous byte-wide write port, and every stored value can be read back.

Top module: `rom_patch_unit`

## Requirements
- R1: After reset every channel register reads back 00h, all channels are disabled, and fetches pass through unchanged.
- R2: Each channel occupies 8 bytes of the configuration space. Channel c starts at byte address 8*c. Offset 0 holds target bits 7:0, offset 1 bits 15:8, offset 2 bits 23:16, offset 3 the low-lane substitute, offset 4 the high-lane substitute, and offset 5 bit 0 the enable. A write with cfg_we_i high stores cfg_wdata_i at the clock edge, and cfg_rdata_o returns the stored value of the addressed byte combinationally.
- R3: A channel matches when target bits 23:1 equal fetch_addr_i bits 23:1. Even and odd targets therefore both hit the word that contains them.
- R4: On a match, rom_rd_o is low and bus_data_o equals {high substitute, low substitute}. For example, target FF5000h with low F9h and high AAh returns AAF9h.
- R5: Without a match, rom_rd_o equals fetch_rd_i and bus_data_o equals rom_data_i.
- R6: A channel whose enable bit is 0 never matches, whatever its target.
- R7: When several enabled channels match, the lowest-numbered one supplies the data.
- R8: A register write changes fetch behaviour only after the clock edge that stores it. A fetch in the same cycle as the write still sees the old setting.
- R9: Offsets 6 and 7, bits 7:1 at offset 5, and channel slots beyond NUM_CH read as 0. Writes to them change no stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | CFG_AW | Configuration byte address (channel, offset) |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration readback of the addressed byte |
| fetch_addr_i | input | 23 (bits 23:1) | Word address of the current fetch |
| fetch_rd_i | input | 1 | CPU read strobe for the fetch |
| rom_rd_o | output | 1 | Read strobe forwarded to the ROM |
| rom_data_i | input | 16 | Word returned by the ROM |
| bus_data_o | output | 16 | Word presented to the CPU's internal bus |

## Verification
The bench aims at odd and even targets inside the same word, the words just beside a target, and two enabled channels aimed at one word. A design that compared bit 0 would miss odd-address fetches. A design that compared too few bits would hit the neighbouring words. A design with the priority reversed would return the higher channel's word. It also fetches in the very cycle of an enabling write: a design with a write-through bypass would substitute one access early. Writes to the reserved offsets and to the upper enable bits are read back to catch decode aliasing into live registers.

// File: rtl/rpu_pkg.sv
// Package: shared constants for the ROM patch substitution unit.
// Assumes a 24-bit byte address space and a 16-bit fetch word.
package rpu_pkg;
    localparam int PATCH_AW   = 24;
    localparam int WORD_W     = 16;
    localparam int SLOT_BYTES = 8;

    // Byte offsets inside one channel slot.
    typedef enum logic [2:0] {
        OFS_TGT_LO = 3'd0,
        OFS_TGT_MI = 3'd1,
        OFS_TGT_HI = 3'd2,
        OFS_SUB_LO = 3'd3,
        OFS_SUB_HI = 3'd4,
        OFS_ENABLE = 3'd5,
        OFS_RSV6   = 3'd6,
        OFS_RSV7   = 3'd7
    } slot_ofs_e;
endpackage

// File: rtl/rpu_regfile.sv
// Module: per-channel configuration storage with a byte-wide write port
// and combinational readback. Assumes cfg_addr is {channel, offset[2:0]}.
// Unmapped bytes read 0 and ignore writes.
module rpu_regfile #(
    parameter int NUM_CH = 4,
    parameter int CFG_AW = 5
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    we,
    input  logic [CFG_AW-1:0]                       addr,
    input  logic [7:0]                              wdata,
    output logic [7:0]                              rdata,
    output logic [NUM_CH-1:0][rpu_pkg::PATCH_AW-1:0] tgt,
    output logic [NUM_CH-1:0][7:0]                  sub_lo,
    output logic [NUM_CH-1:0][7:0]                  sub_hi,
    output logic [NUM_CH-1:0]                       en
);
    import rpu_pkg::*;

    localparam int CHF_W = CFG_AW - 3;

    logic [CHF_W-1:0] acc_ch;
    slot_ofs_e        acc_ofs;

    assign acc_ch  = addr[CFG_AW-1:3];
    assign acc_ofs = slot_ofs_e'(addr[2:0]);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel = we && (int'(acc_ch) == c);

        // Store target, substitute bytes and enable for channel c.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tgt[c]    <= '0;
                sub_lo[c] <= '0;
                sub_hi[c] <= '0;
                en[c]     <= 1'b0;
            end else if (sel) begin
                case (acc_ofs)
                    OFS_TGT_LO: tgt[c][7:0]   <= wdata;
                    OFS_TGT_MI: tgt[c][15:8]  <= wdata;
                    OFS_TGT_HI: tgt[c][23:16] <= wdata;
                    OFS_SUB_LO: sub_lo[c]     <= wdata;
                    OFS_SUB_HI: sub_hi[c]     <= wdata;
                    OFS_ENABLE: en[c]         <= wdata[0];
                    default:    ;
                endcase
            end
        end
    end

    // Return the addressed byte, zero for anything unmapped.
    always_comb begin
        rdata = 8'h00;
        for (int c = 0; c < NUM_CH; c++) begin
            if (int'(acc_ch) == c) begin
                case (acc_ofs)
                    OFS_TGT_LO: rdata = tgt[c][7:0];
                    OFS_TGT_MI: rdata = tgt[c][15:8];
                    OFS_TGT_HI: rdata = tgt[c][23:16];
                    OFS_SUB_LO: rdata = sub_lo[c];
                    OFS_SUB_HI: rdata = sub_hi[c];
                    OFS_ENABLE: rdata = {7'b0, en[c]};
                    default:    rdata = 8'h00;
                endcase
            end
        end
    end
endmodule

// File: rtl/rpu_match.sv
// Module: word-granular comparators plus a lowest-index priority encoder.
// Assumes the caller passes only address bits above bit 0.
module rpu_match #(
    parameter int NUM_CH = 4,
    parameter int SEL_W  = 2
) (
    input  logic [NUM_CH-1:0][rpu_pkg::PATCH_AW-2:0] cmp_word,
    input  logic [NUM_CH-1:0]                       en,
    input  logic [rpu_pkg::PATCH_AW-2:0]            fetch_word,
    output logic                                    hit,
    output logic [SEL_W-1:0]                        sel
);
    logic [NUM_CH-1:0] hit_vec;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        assign hit_vec[c] = en[c] && (cmp_word[c] == fetch_word);
    end

    // Pick the lowest-numbered hitting channel.
    always_comb begin
        sel = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (hit_vec[c]) sel = SEL_W'(c);
        end
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/rpu_datamux.sv
// Module: gates the ROM read strobe and steers the substitute or ROM word
// onto the internal bus. Assumes sel is valid whenever hit is high.
module rpu_datamux #(
    parameter int NUM_CH = 4,
    parameter int SEL_W  = 2
) (
    input  logic [NUM_CH-1:0][7:0]        sub_lo,
    input  logic [NUM_CH-1:0][7:0]        sub_hi,
    input  logic                          hit,
    input  logic [SEL_W-1:0]              sel,
    input  logic                          fetch_rd,
    input  logic [rpu_pkg::WORD_W-1:0]    rom_data,
    output logic                          rom_rd,
    output logic [rpu_pkg::WORD_W-1:0]    bus_data
);
    logic [rpu_pkg::WORD_W-1:0] sub_word;

    // Build the selected substitute word.
    always_comb begin
        sub_word = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (int'(sel) == c) sub_word = {sub_hi[c], sub_lo[c]};
        end
    end

    assign rom_rd   = fetch_rd && !hit;
    assign bus_data = hit ? sub_word : rom_data;
endmodule

// File: rtl/rom_patch_unit.sv
// Module: top of the ROM patch substitution unit. Holds NUM_CH channels.
// On a word match it blocks the ROM strobe and returns the stored word.
// Assumes a synchronous active-low reset and a combinational fetch path.
module rom_patch_unit #(
    parameter int NUM_CH = 4,
    parameter int CH_BITS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int CFG_AW = CH_BITS + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [7:0]        cfg_wdata_i,
    output logic [7:0]        cfg_rdata_o,
    input  logic [23:1]       fetch_addr_i,
    input  logic              fetch_rd_i,
    output logic              rom_rd_o,
    input  logic [15:0]       rom_data_i,
    output logic [15:0]       bus_data_o
);
    import rpu_pkg::*;

    logic [NUM_CH-1:0][PATCH_AW-1:0] ch_tgt;
    logic [NUM_CH-1:0][PATCH_AW-2:0] ch_word;
    logic [NUM_CH-1:0][7:0]          ch_lo;
    logic [NUM_CH-1:0][7:0]          ch_hi;
    logic [NUM_CH-1:0]               ch_en;
    logic                            any_hit;
    logic [CH_BITS-1:0]              hit_sel;

    rpu_regfile #(.NUM_CH(NUM_CH), .CFG_AW(CFG_AW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we_i),
        .addr   (cfg_addr_i),
        .wdata  (cfg_wdata_i),
        .rdata  (cfg_rdata_o),
        .tgt    (ch_tgt),
        .sub_lo (ch_lo),
        .sub_hi (ch_hi),
        .en     (ch_en)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_word
        assign ch_word[c] = ch_tgt[c][PATCH_AW-1:1];
    end

    rpu_match #(.NUM_CH(NUM_CH), .SEL_W(CH_BITS)) u_match (
        .cmp_word   (ch_word),
        .en         (ch_en),
        .fetch_word (fetch_addr_i),
        .hit        (any_hit),
        .sel        (hit_sel)
    );

    rpu_datamux #(.NUM_CH(NUM_CH), .SEL_W(CH_BITS)) u_mux (
        .sub_lo   (ch_lo),
        .sub_hi   (ch_hi),
        .hit      (any_hit),
        .sel      (hit_sel),
        .fetch_rd (fetch_rd_i),
        .rom_data (rom_data_i),
        .rom_rd   (rom_rd_o),
        .bus_data (bus_data_o)
    );
endmodule

// File: rtl/rpu_checker.sv
// Module: property checker for rom_patch_unit, attached through bind.
// Watches ports plus the stored register state from the register file.
module rpu_checker #(
    parameter int NUM_CH = 4,
    parameter int CFG_AW = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_we_i,
    input logic [CFG_AW-1:0]       cfg_addr_i,
    input logic [7:0]              cfg_wdata_i,
    input logic [7:0]              cfg_rdata_o,
    input logic [23:1]             fetch_addr_i,
    input logic                    fetch_rd_i,
    input logic                    rom_rd_o,
    input logic [15:0]             rom_data_i,
    input logic [15:0]             bus_data_o,
    input logic [NUM_CH-1:0][23:0] ch_tgt,
    input logic [NUM_CH-1:0][7:0]  ch_lo,
    input logic [NUM_CH-1:0][7:0]  ch_hi,
    input logic [NUM_CH-1:0]       ch_en
);
    logic stored_slot;
    logic ch0_hit;

    assign stored_slot = (int'(cfg_addr_i[CFG_AW-1:3]) < NUM_CH) && (cfg_addr_i[2:0] < 3'd5);
    assign ch0_hit     = ch_en[0] && (ch_tgt[0][23:1] == fetch_addr_i);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_rdata_o == 8'h00 && ch_en == '0));

    assert_write_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && stored_slot) |=> ($stable(cfg_addr_i) |-> cfg_rdata_o == $past(cfg_wdata_i)));

    assert_strobe_only_from_cpu_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd_o |-> fetch_rd_i);

    assert_passthrough_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd_o |-> bus_data_o == rom_data_i);

    assert_all_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en == '0) |-> (rom_rd_o == fetch_rd_i && bus_data_o == rom_data_i));

    assert_ch0_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ch0_hit |-> (bus_data_o == {ch_hi[0], ch_lo[0]} && !rom_rd_o));
endmodule

bind rom_patch_unit rpu_checker #(.NUM_CH(NUM_CH), .CFG_AW(CFG_AW)) u_rpu_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we_i     (cfg_we_i),
    .cfg_addr_i   (cfg_addr_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .cfg_rdata_o  (cfg_rdata_o),
    .fetch_addr_i (fetch_addr_i),
    .fetch_rd_i   (fetch_rd_i),
    .rom_rd_o     (rom_rd_o),
    .rom_data_i   (rom_data_i),
    .bus_data_o   (bus_data_o),
    .ch_tgt       (ch_tgt),
    .ch_lo        (ch_lo),
    .ch_hi        (ch_hi),
    .ch_en        (ch_en)
);

// File: tb/rom_patch_unit_test.sv
// Bench: directed corner cases plus seeded random traffic, checked
// against a reference model kept in bench variables.
module rom_patch_unit_test;
    localparam int NCH = 4;
    localparam int AW  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic [23:1]   fetch_addr = '0;
    logic          fetch_rd = 1'b0;
    logic          rom_rd;
    logic [15:0]   rom_data = '0;
    logic [15:0]   bus_data;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [23:0] m_tgt [NCH];
    logic [7:0]  m_lo  [NCH];
    logic [7:0]  m_hi  [NCH];
    logic        m_en  [NCH];

    rom_patch_unit #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
        .cfg_rdata_o(cfg_rdata),
        .fetch_addr_i(fetch_addr), .fetch_rd_i(fetch_rd), .rom_rd_o(rom_rd),
        .rom_data_i(rom_data), .bus_data_o(bus_data)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] model_read(input logic [AW-1:0] a);
        int c = int'(a[AW-1:3]);
        case (a[2:0])
            3'd0: return m_tgt[c][7:0];
            3'd1: return m_tgt[c][15:8];
            3'd2: return m_tgt[c][23:16];
            3'd3: return m_lo[c];
            3'd4: return m_hi[c];
            3'd5: return {7'b0, m_en[c]};
            default: return 8'h00;
        endcase
    endfunction

    function automatic int model_hit(input logic [23:0] fa);
        for (int c = 0; c < NCH; c++)
            if (m_en[c] && m_tgt[c][23:1] == fa[23:1]) return c;
        return -1;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input int c, input int ofs, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(c * 8 + ofs); cfg_wdata = d;
        @(posedge clk);
        case (ofs)
            0: m_tgt[c][7:0]   = d;
            1: m_tgt[c][15:8]  = d;
            2: m_tgt[c][23:16] = d;
            3: m_lo[c] = d;
            4: m_hi[c] = d;
            5: m_en[c] = d[0];
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic program_ch(input int c, input logic [23:0] t, input logic [7:0] lo,
                              input logic [7:0] hi, input logic e);
        wr(c, 0, t[7:0]); wr(c, 1, t[15:8]); wr(c, 2, t[23:16]);
        wr(c, 3, lo); wr(c, 4, hi); wr(c, 5, {7'b0, e});
    endtask

    task automatic fetch(input string req, input logic [23:0] fa, input logic rd, input logic [15:0] rdat);
        int h;
        fetch_addr = fa[23:1]; fetch_rd = rd; rom_data = rdat;
        #1;
        h = model_hit(fa);
        if (h >= 0) begin
            check(req, {16'h0, bus_data}, {16'h0, m_hi[h], m_lo[h]});
            check(req, {31'h0, rom_rd}, 32'h0);
        end else begin
            check(req, {16'h0, bus_data}, {16'h0, rdat});
            check(req, {31'h0, rom_rd}, {31'h0, rd});
        end
    endtask

    task automatic readback(input string req, input logic [AW-1:0] a);
        cfg_addr = a; #1;
        check(req, {24'h0, cfg_rdata}, {24'h0, model_read(a)});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd91));
        for (int c = 0; c < NCH; c++) begin
            m_tgt[c] = '0; m_lo[c] = '0; m_hi[c] = '0; m_en[c] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 32; a++) readback("R1", AW'(a));
        fetch("R1", 24'h000000, 1'b1, 16'h1234);

        // R2/R4: example word, even target
        program_ch(0, 24'hFF5000, 8'hF9, 8'hAA, 1'b1);
        for (int o = 0; o < 6; o++) readback("R2", AW'(o));
        fetch("R4", 24'hFF5000, 1'b1, 16'h5555);
        check("R4", {16'h0, bus_data}, 32'h0000AAF9);
        // R3: odd byte of the same word also hits, neighbours miss
        fetch("R3", 24'hFF5001, 1'b1, 16'h5555);
        fetch("R3", 24'hFF5002, 1'b1, 16'h7777);
        check("R3", {31'h0, rom_rd}, 32'h1);
        fetch("R3", 24'hFF4FFE, 1'b1, 16'h6666);
        fetch("R5", 24'hFF4FFE, 1'b0, 16'h6666);

        // R3: odd target stored in channel 1
        program_ch(1, 24'h123457, 8'h3C, 8'hF9, 1'b1);
        fetch("R3", 24'h123456, 1'b1, 16'h0);
        check("R3", {16'h0, bus_data}, 32'h0000F93C);

        // R7: channel 2 aims at same word as channel 1
        program_ch(2, 24'h123456, 8'h11, 8'h22, 1'b1);
        fetch("R7", 24'h123457, 1'b1, 16'h0);
        check("R7", {16'h0, bus_data}, 32'h0000F93C);
        // R6: disabling channel 1 hands the word to channel 2
        wr(1, 5, 8'h00);
        fetch("R6", 24'h123456, 1'b1, 16'h0);
        check("R6", {16'h0, bus_data}, 32'h00002211);
        wr(2, 5, 8'hFE);
        fetch("R6", 24'h123456, 1'b1, 16'hBEEF);
        check("R6", {16'h0, bus_data}, 32'h0000BEEF);

        // R8: fetch in the same cycle as the enabling write sees old state
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(2 * 8 + 5); cfg_wdata = 8'h01;
        fetch_addr = 23'h091A2B; fetch_rd = 1'b1; rom_data = 16'hC0DE; #1;
        check("R8", {16'h0, bus_data}, 32'h0000C0DE);
        @(posedge clk); m_en[2] = 1'b1;
        @(negedge clk); cfg_we = 1'b0;
        fetch("R8", 24'h123456, 1'b1, 16'hC0DE);
        check("R8", {16'h0, bus_data}, 32'h00002211);

        // R9: reserved bytes and upper enable bits
        wr(3, 6, 8'hFF); wr(3, 7, 8'hA5); wr(3, 5, 8'hFE);
        readback("R9", AW'(3 * 8 + 6));
        readback("R9", AW'(3 * 8 + 7));
        readback("R9", AW'(3 * 8 + 5));
        for (int o = 0; o < 5; o++) readback("R9", AW'(3 * 8 + o));

        // Random traffic
        for (int i = 0; i < 400; i++) begin
            int c = int'($urandom_range(NCH - 1, 0));
            if ($urandom_range(3, 0) == 0) begin
                int o = int'($urandom_range(7, 0));
                logic [7:0] d = 8'($urandom);
                if (o == 5) d[0] = ($urandom_range(3, 0) != 0);
                wr(c, o, d);
                readback("R2", AW'(c * 8 + o));
            end else begin
                logic [23:0] fa = 24'($urandom);
                if ($urandom_range(1, 0) == 1) fa = {m_tgt[c][23:1], 1'($urandom)};
                fetch("R5", fa, 1'($urandom), 16'($urandom));
                @(negedge clk);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule